// File: doc/BRIEF.md
# Platform Power-Up Sequencer

This block brings a processor board from cold to running. A power-on request switches on four supply rails, one after another in a fixed order from rail 0 (the 1.5 V rail) up to rail 3 (the 12 V rail). Each rail waits for its own power-good input before the next rail is switched on. Once every rail is good, the sequencer waits for the platform clock generators to report lock. It then holds the processor in reset for a fixed number of further cycles before it releases it.

Each waiting stage is bounded by a cycle limit that the board sets on a plain input. A rail that never reports good, a clock that never locks, or the loss of any good or lock indication after it was confirmed all count as a fault. A fault latches a flag and switches the rails off again in reverse order. A power-off request takes the same reverse path without the fault flag. The processor reset is asserted in every state except running. All pins are level control and status signals. No data moves through the block, so there is no stream handshake.

Top module: `pwr_seq_top`

## Requirements
- R1: After rst_n is released, all rail enables are 0, cpu_reset is 1 and seq_fault is 0.
- R2: A pwr_on_req sampled while idle turns on rail 0 at that clock edge. Rail enables always form a contiguous run from bit 0 upward, so rail k is never on while rail k-1 is off.
- R3: Rail k+1 is switched on at the same clock edge at which rail_pg[k] is first sampled high while rail k is the newest rail.
- R4: The stage limit L is 1 or more. If the newest rail's power-good has not been sampled high at any of the L edges that follow its enable, seq_fault rises at the L-th edge and shedding begins.
- R5: After the last rail is good, clk_lock must be sampled high within L edges, otherwise seq_fault is set and shedding begins.
- R6: cpu_reset falls exactly HOLD_CYCLES edges after the edge at which clk_lock is first seen in the lock-wait stage. If clk_lock drops during that hold, seq_fault is set.
- R7: cpu_reset is 0 only in the running state, and only while every rail enable is 1.
- R8: When shedding, the rails go off in reverse order, one rail per cycle. Shedding starts at the edge after the shed decision and ends with every enable at 0.
- R9: A pwr_off_req in any active state asserts cpu_reset at the next edge and sheds the rails without setting seq_fault. It takes priority over a power-good or lock arriving in the same cycle.
- R10: Losing any confirmed rail_pg bit, or losing clk_lock after it was confirmed, re-asserts cpu_reset at the next edge, sets seq_fault and sheds the rails.
- R11: seq_fault stays set while idle until the next accepted pwr_on_req, which clears it. pwr_on_req has no effect unless the block is idle, and pwr_off_req has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on request, sampled while idle |
| pwr_off_req | input | 1 | Power-off request |
| rail_pg | input | N_RAILS | Power-good per rail, bit 0 is the first rail |
| clk_lock | input | 1 | Platform clock generators locked |
| stage_limit | input | TW | Wait limit in cycles for each rail stage and the lock stage (at least 1) |
| rail_en | output | N_RAILS | Rail switch enables |
| cpu_reset | output | 1 | Processor reset, active high |
| seq_fault | output | 1 | Latched sequencing fault |

## Verification
Two situations are hard to reach from the pins. The first is the exact timeout boundary, where a rail's power-good arrives on the last permitted edge rather than one edge later. The second is a power-good or lock that comes and goes inside a short window, such as the hold before reset release. The bench models each rail's power-good and the clock lock as delays counted from the observed enables, so the timeout edges can be hit exactly. It also includes directed runs that drop lock one cycle into the hold window, drop a lower rail while a higher one is ramping, and raise the off request in the same cycle that power-good arrives. Random delays around the limit then cover both outcomes of every stage.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_LOCKW,
    ST_HOLD,
    ST_RUN,
    ST_SHED
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_timer.sv
// Stage cycle counter: cleared on every stage change, saturating, flags the last permitted edge.
module pwr_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + TW'(1);
  end

  assign hit = (cnt == (limit - TW'(1)));
endmodule

// File: rtl/pwr_seq_rail_bank.sv
// Holds the number of rails switched on; enables are a thermometer of that count.
module pwr_seq_rail_bank #(
  parameter int N_RAILS = 4,
  parameter int CW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up,
  input  logic               dn,
  output logic [CW-1:0]      rail_cnt,
  output logic [N_RAILS-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  rail_cnt <= '0;
    else if (up && rail_cnt != CW'(N_RAILS))     rail_cnt <= rail_cnt + CW'(1);
    else if (dn && rail_cnt != '0)               rail_cnt <= rail_cnt - CW'(1);
  end

  for (genvar g = 0; g < N_RAILS; g++) begin : g_en
    assign en[g] = (rail_cnt > CW'(g));
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int N_RAILS = 4,
  parameter int CW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               on_req,
  input  logic               off_req,
  input  logic [N_RAILS-1:0] pg,
  input  logic               lock,
  input  logic [CW-1:0]      rail_cnt,
  input  logic               hit,
  output logic               up,
  output logic               dn,
  output logic               tmr_clr,
  output logic               fault,
  output seq_state_e         state
);
  seq_state_e nxt;
  logic       fset, fclr;
  logic [N_RAILS-1:0] conf_mask, top_mask;
  logic       all_pg, lower_lost, top_good;

  always_comb begin
    for (int i = 0; i < N_RAILS; i++) begin
      conf_mask[i] = ((i + 1) < int'(rail_cnt));
      top_mask[i]  = ((i + 1) == int'(rail_cnt));
    end
  end

  assign all_pg     = &pg;
  assign lower_lost = ((pg & conf_mask) != conf_mask);
  assign top_good   = |(pg & top_mask);

  always_comb begin
    nxt = state; up = 1'b0; dn = 1'b0; tmr_clr = 1'b1; fset = 1'b0; fclr = 1'b0;
    unique case (state)
      ST_IDLE: if (on_req) begin nxt = ST_RAMP; up = 1'b1; fclr = 1'b1; end
      ST_RAMP: begin
        if (off_req)          nxt = ST_SHED;
        else if (lower_lost)  begin nxt = ST_SHED; fset = 1'b1; end
        else if (top_good) begin
          if (rail_cnt == CW'(N_RAILS)) nxt = ST_LOCKW;
          else                          up  = 1'b1;
        end
        else if (hit)         begin nxt = ST_SHED; fset = 1'b1; end
        else                  tmr_clr = 1'b0;
      end
      ST_LOCKW: begin
        if (off_req)          nxt = ST_SHED;
        else if (!all_pg)     begin nxt = ST_SHED; fset = 1'b1; end
        else if (lock)        nxt = ST_HOLD;
        else if (hit)         begin nxt = ST_SHED; fset = 1'b1; end
        else                  tmr_clr = 1'b0;
      end
      ST_HOLD: begin
        if (off_req)                 nxt = ST_SHED;
        else if (!all_pg || !lock)   begin nxt = ST_SHED; fset = 1'b1; end
        else if (hit)                nxt = ST_RUN;
        else                         tmr_clr = 1'b0;
      end
      ST_RUN: begin
        if (off_req)                 nxt = ST_SHED;
        else if (!all_pg || !lock)   begin nxt = ST_SHED; fset = 1'b1; end
      end
      ST_SHED: begin
        if (rail_cnt == '0) nxt = ST_IDLE;
        else                dn  = 1'b1;
      end
      default: nxt = ST_SHED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      fault <= 1'b0;
    end else begin
      state <= nxt;
      if (fclr)      fault <= 1'b0;
      else if (fset) fault <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int N_RAILS     = 4,
  parameter int TW          = 16,
  parameter int HOLD_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_on_req,
  input  logic               pwr_off_req,
  input  logic [N_RAILS-1:0] rail_pg,
  input  logic               clk_lock,
  input  logic [TW-1:0]      stage_limit,
  output logic [N_RAILS-1:0] rail_en,
  output logic               cpu_reset,
  output logic               seq_fault
);
  localparam int CW = $clog2(N_RAILS + 1);

  seq_state_e    state;
  logic [CW-1:0] rail_cnt;
  logic          up, dn, tmr_clr, hit;
  logic [TW-1:0] limit_sel;

  assign limit_sel = (state == ST_HOLD) ? TW'(HOLD_CYCLES) : stage_limit;

  pwr_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(limit_sel), .hit(hit)
  );

  pwr_seq_rail_bank #(.N_RAILS(N_RAILS), .CW(CW)) u_rails (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .rail_cnt(rail_cnt), .en(rail_en)
  );

  pwr_seq_fsm #(.N_RAILS(N_RAILS), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .on_req(pwr_on_req), .off_req(pwr_off_req),
    .pg(rail_pg), .lock(clk_lock), .rail_cnt(rail_cnt), .hit(hit),
    .up(up), .dn(dn), .tmr_clr(tmr_clr), .fault(seq_fault), .state(state)
  );

  assign cpu_reset = (state != ST_RUN);
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int N_RAILS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_on_req,
  input logic               pwr_off_req,
  input logic [N_RAILS-1:0] rail_pg,
  input logic               clk_lock,
  input logic [N_RAILS-1:0] rail_en,
  input logic               cpu_reset,
  input logic               seq_fault
);
  AST_RAILS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en & (rail_en + 1'b1)) == '0)); // R2

  AST_RUN_NEEDS_ALL_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_reset |-> (&rail_en)); // R7

  AST_ONE_RAIL_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rail_en) <= $countones($past(rail_en)) + 1) &&
    ($countones(rail_en) + 1 >= $countones($past(rail_en)))); // R8

  AST_OFF_ASSERTS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |=> cpu_reset); // R9

  AST_LOSS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_reset && !pwr_off_req && (!(&rail_pg) || !clk_lock)) |=> (cpu_reset && seq_fault)); // R10

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_fault && !pwr_on_req) |=> seq_fault); // R11
endmodule

bind pwr_seq_top pwr_seq_checker #(.N_RAILS(N_RAILS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
  .rail_pg(rail_pg), .clk_lock(clk_lock), .rail_en(rail_en),
  .cpu_reset(cpu_reset), .seq_fault(seq_fault)
);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       on_req = 1'b0, off_req = 1'b0;
  logic [3:0] pg = '0;
  logic       lock = 1'b0;
  logic [7:0] lim = 8'd5;
  logic [3:0] en;
  logic       rst_o, fault;

  int checks = 0, fails = 0;
  int d[4];
  int on_cnt[4];
  int dl = 1, lk_cnt = 0, hold_cnt = 0, prev_ones = 0;
  logic [3:0] kill_pg = '0;
  bit kill_lk = 0;
  bit running = 0;

  always #5 clk = ~clk;

  pwr_seq_top #(.N_RAILS(4), .TW(8), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(on_req), .pwr_off_req(off_req),
    .rail_pg(pg), .clk_lock(lock), .stage_limit(lim),
    .rail_en(en), .cpu_reset(rst_o), .seq_fault(fault)
  );

  function automatic int ones(input logic [3:0] v);
    return $countones(v);
  endfunction

  function automatic logic [3:0] thermo(input int k);
    logic [4:0] t;
    t = (5'd1 << k) - 5'd1;
    return t[3:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // One cycle: sample outputs at the falling edge, then update the rail and clock models.
  task automatic step();
    @(negedge clk);
    check((en & (en + 4'd1)) == 4'd0, "R2", en, thermo(ones(en)));
    check((ones(en) - prev_ones <= 1) && (prev_ones - ones(en) <= 1), "R8", ones(en), prev_ones);
    prev_ones = ones(en);
    if (lock && rst_o) hold_cnt++;
    if (&pg) lk_cnt++; else lk_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      on_cnt[i] = en[i] ? on_cnt[i] + 1 : 0;
      pg[i] = en[i] && (on_cnt[i] >= d[i]) && !kill_pg[i];
    end
    lock = !kill_lk && (lk_cnt > 0) && (lk_cnt >= dl);
  endtask

  task automatic drain();
    for (int k = 0; k < 20; k++) begin
      if (en == 4'd0) break;
      step();
    end
    step(); step();
    kill_pg = '0; kill_lk = 0; on_req = 0; off_req = 0; running = 0;
  endtask

  task automatic bringup(input int l);
    int fr, fon, flk, fsteps, prev_c;
    bit lkf, fseen;
    logic [3:0] fen;
    lim = 8'(l); hold_cnt = 0; kill_pg = '0; kill_lk = 0;
    fr = -1;
    for (int i = 0; i < 4; i++) if (fr < 0 && d[i] > l) fr = i;
    lkf = (fr < 0) && (dl > l);
    fseen = 0; fsteps = 0; fon = 0; flk = 0; fen = '0;
    on_req = 1; step(); on_req = 0;
    check(en == 4'b0001, "R2", en, 1);
    check(!fault, "R11", fault, 0);
    prev_c = 1;
    for (int k = 0; k < 300; k++) begin
      step();
      if (fseen) fsteps++;
      else if (fault) begin
        fseen = 1; fen = en; flk = lk_cnt;
        fon = (ones(en) > 0) ? on_cnt[ones(en) - 1] : -1;
      end
      if (!fseen && ones(en) > prev_c) begin
        check(on_cnt[ones(en) - 2] == d[ones(en) - 2] + 1, "R3",
              on_cnt[ones(en) - 2], d[ones(en) - 2] + 1);
        prev_c = ones(en);
      end
      if (!rst_o || (fseen && en == 4'd0)) break;
    end
    if (fr >= 0) begin
      check(fseen && fen == thermo(fr + 1), "R4", fen, thermo(fr + 1));
      check(fon == l + 1, "R4", fon, l + 1);
      check(fsteps == fr + 1, "R8", fsteps, fr + 1);
    end else if (lkf) begin
      check(fseen && fen == 4'hF, "R5", fen, 15);
      check(flk == l + 1, "R5", flk, l + 1);
      check(fsteps == 4, "R8", fsteps, 4);
    end else begin
      check(!rst_o && !fault, "R6", rst_o, 0);
      check(hold_cnt == HOLD, "R6", hold_cnt, HOLD);
      check(en == 4'hF, "R7", en, 15);
    end
    running = !rst_o;
    if (!running) drain();
  endtask

  // mode 0: off request, 1: drop one rail's good, 2: drop clock lock
  task automatic teardown(input int mode, input int r);
    if (mode == 0) off_req = 1;
    else if (mode == 1) begin pg[r] = 0; kill_pg[r] = 1; end
    else begin lock = 0; kill_lk = 1; end
    step(); off_req = 0;
    check(rst_o, (mode == 0) ? "R9" : "R10", rst_o, 1);
    check(fault == (mode != 0), (mode == 0) ? "R9" : "R10", fault, mode != 0);
    check(en == 4'hF, "R8", en, 15);
    for (int k = 3; k >= 0; k--) begin
      step();
      check(en == thermo(k), "R8", en, thermo(k));
    end
    drain();
  endtask

  task automatic set_d(input int a);
    for (int i = 0; i < 4; i++) d[i] = a;
    dl = a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    set_d(1);
    for (int i = 0; i < 4; i++) on_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check(en == 4'd0 && rst_o && !fault, "R1", {en, rst_o, fault}, 2);

    // off request while idle does nothing
    off_req = 1; step(); off_req = 0; step(); step();
    check(en == 4'd0 && rst_o && !fault, "R11", {en, rst_o, fault}, 2);

    // boundary: every stage answers on its last permitted edge
    set_d(5); bringup(5);
    // on request while running is ignored
    on_req = 1; step(); on_req = 0; step();
    check(!rst_o && en == 4'hF && !fault, "R11", {en, rst_o}, 30);
    teardown(0, 0);

    // rail 2 one edge late
    set_d(5); d[2] = 6; bringup(5);
    repeat (4) step();
    check(fault && en == 4'd0 && rst_o, "R11", fault, 1);

    // lock one edge late
    set_d(5); dl = 6; bringup(5);

    // faults by losing a rail and losing lock while running
    set_d(2); bringup(4); teardown(1, 0);
    set_d(3); bringup(4); teardown(2, 0);

    // off request coincides with rail 0 good
    set_d(3); lim = 8'd20;
    on_req = 1; step(); on_req = 0;
    step(); step();
    off_req = 1; step(); off_req = 0;
    check(en == 4'b0001 && rst_o && !fault, "R9", en, 1);
    step();
    check(en == 4'd0, "R8", en, 0);
    drain();
    check(!fault, "R9", fault, 0);

    // lower rail lost while rail 1 ramps
    set_d(2); d[1] = 15; lim = 8'd20;
    on_req = 1; step(); on_req = 0;
    for (int k = 0; k < 6; k++) step();
    check(en == 4'b0011, "R3", en, 3);
    pg[0] = 0; kill_pg[0] = 1; step();
    check(fault && rst_o && en == 4'b0011, "R10", fault, 1);
    drain();

    // lock drops during the hold window
    set_d(2); lim = 8'd10;
    on_req = 1; step(); on_req = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (lock) break;
    end
    step();
    lock = 0; kill_lk = 1; step();
    check(fault && rst_o, "R6", fault, 1);
    drain();

    // random delays around the limit
    for (int it = 0; it < 40; it++) begin
      int l;
      l = 2 + int'($urandom % 9);
      for (int i = 0; i < 4; i++) d[i] = 1 + int'($urandom % (l + 2));
      dl = 1 + int'($urandom % (l + 2));
      bringup(l);
      if (running) teardown(int'($urandom % 3), int'($urandom % 4));
    end

    summary();
    $finish;
  end
endmodule